// File: doc/BRIEF.md
# Timed Memory Request Replayer

This block plays back a recorded sequence of memory requests onto a valid/ready request port, spacing them the way they were spaced when they were recorded. Records come in through a FIFO-style pop interface. Each record carries a read/write command, an address, a size, optional flags, an optional program counter and a timestamp. A special entry marks the end of the stream. A free-running tick count supplied from outside serves as the current time. A global offset input moves the whole schedule earlier, so the first request leaves at its timestamp minus that offset.

After each successful hand-off, the next request is timed relative to the tick at which the previous one was accepted. The gap used is the difference between the two records' timestamps. The downstream side can refuse a request. A refused request is held unchanged and the block waits for a retry strobe. When the strobe arrives, the held request is offered again in that same cycle. The schedule moves on only after a successful hand-off. Write requests carry a payload filled with the byte 0x0A. Responses are always accepted and dropped. Three counters report first attempts, first-attempt refusals and successful retries.

The controller is a four-state machine:
- FETCH: pops the next record. It goes to ARMED on a data record and to FINISHED on the end marker.
- ARMED: offers the request once the tick count reaches the target. It goes back to FETCH on acceptance, or to STALLED on refusal.
- STALLED: offers the request only while retry is high. It goes to FETCH when a retry is accepted.
- FINISHED: terminal. It asserts trace-done.

Top module: `req_replayer`

## Requirements
- R1: After reset, the outputs are: `req_valid` 0, `trace_done` 0, `order_err` 0, all three counters 0, and `rsp_ready` 1.
- R2: The first request is offered first in the cycle whose tick equals the first timestamp minus `time_offset`, clamped at zero. This assumes that tick has not yet passed when the record is popped.
- R3: After a request is accepted at tick T, the next request is first offered at tick max(T + d, T + 2). Here d is the new timestamp minus the previous record's timestamp.
- R4: A record whose timestamp is smaller than the previous record's sets `order_err`. This flag stays set until reset, and the gap for that record is taken as zero.
- R5: After a refusal (`req_valid` high, `req_ready` low), `req_valid` stays low in every cycle without `retry_in`. The address, size, command, flags and program counter stay unchanged.
- R6: While a request is held, `req_valid` rises in the same cycle as `retry_in` and carries the held request. Acceptance of that retry restarts the schedule from that cycle's tick, as in R3.
- R7: For a write (`req_write` = 1), every byte of `req_data` is 0x0A. For a read, `req_data` is all zero.
- R8: `rsp_ready` is constantly 1, and `rsp_valid` has no effect on timing or content of requests.
- R9: Popping an entry with `rec_eos` = 1 raises `trace_done` permanently. After that, `req_valid` and `rec_ready` stay 0.
- R10: A record with `rec_has_flags` = 0 is issued with `req_flags` = 0. A record with `rec_has_pc` = 0 is issued with `req_pc` = 0. Otherwise the record's values pass through.
- R11: `cnt_attempts` counts first offers, `cnt_first_fail` counts first offers that were refused, and `cnt_retry_ok` counts accepted retries.
- R12: Requests are issued in record order, each exactly once as a first offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_now | input | TW | Current time, free-running |
| time_offset | input | TW | Global offset subtracted from the first timestamp |
| rec_valid | input | 1 | Record entry available |
| rec_ready | output | 1 | Record entry popped this cycle when valid |
| rec_eos | input | 1 | Entry is the end-of-stream marker |
| rec_write | input | 1 | 1 = write, 0 = read |
| rec_addr | input | AW | Record address |
| rec_size | input | SW | Record size in bytes |
| rec_has_flags | input | 1 | Flags field present |
| rec_flags | input | FW | Record flags |
| rec_has_pc | input | 1 | Program counter field present |
| rec_pc | input | PW | Record program counter |
| rec_stamp | input | TW | Record timestamp |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | Request command |
| req_addr | output | AW | Request address |
| req_size | output | SW | Request size |
| req_flags | output | FW | Request flags |
| req_pc | output | PW | Request program counter |
| req_data | output | 8*DB | Write payload |
| retry_in | input | 1 | Downstream retry strobe |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response accepted (always 1) |
| trace_done | output | 1 | End of stream reached |
| order_err | output | 1 | Decreasing timestamp seen (sticky) |
| cnt_attempts | output | CW | First-offer count |
| cnt_first_fail | output | CW | Refused first-offer count |
| cnt_retry_ok | output | CW | Accepted retry count |

## Verification
The hardest case to reach is a hold that lasts several cycles and ends with a retry accepted on a later strobe. During such a hold, `req_ready` may be high when no retry is present, and that must not let the request through. A retry strobe that arrives together with a refusal must keep the request held. The stimulus drives `req_ready`, `retry_in` and `rsp_valid` independently at random every cycle, so these cases happen repeatedly. Meanwhile, timestamp gaps that are often zero or below the two-cycle floor, together with one deliberately decreasing timestamp, exercise the clamping in R3 and R4 right after a retried send.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        ST_FETCH,
        ST_ARMED,
        ST_STALLED,
        ST_FINISHED
    } rr_state_e;

    localparam logic [7:0] WR_FILL_BYTE = 8'h0A;
    localparam int NUM_CNT = 3;
endpackage

// File: rtl/rr_sched.sv
module rr_sched #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sent,
    input  logic [TW-1:0] tick_now,
    input  logic [TW-1:0] time_offset,
    input  logic [TW-1:0] rec_stamp,
    output logic [TW-1:0] target,
    output logic          order_err
);
    logic          first_q;
    logic [TW-1:0] prev_stamp_q;
    logic [TW-1:0] base_q;
    logic [TW-1:0] target_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q      <= 1'b1;
            prev_stamp_q <= '0;
            base_q       <= '0;
            target_q     <= '0;
            err_q        <= 1'b0;
        end else begin
            if (sent) begin
                base_q <= tick_now;
            end
            if (load) begin
                prev_stamp_q <= rec_stamp;
                first_q      <= 1'b0;
                if (first_q) begin
                    target_q <= (rec_stamp >= time_offset) ? rec_stamp - time_offset : '0;
                end else if (rec_stamp >= prev_stamp_q) begin
                    target_q <= base_q + (rec_stamp - prev_stamp_q);
                end else begin
                    target_q <= base_q;
                    err_q    <= 1'b1;
                end
            end
        end
    end

    assign target    = target_q;
    assign order_err = err_q;

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/rr_payload.sv
module rr_payload #(
    parameter int AW = 32,
    parameter int SW = 8,
    parameter int FW = 8,
    parameter int PW = 32,
    parameter int DB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          rec_write,
    input  logic [AW-1:0] rec_addr,
    input  logic [SW-1:0] rec_size,
    input  logic          rec_has_flags,
    input  logic [FW-1:0] rec_flags,
    input  logic          rec_has_pc,
    input  logic [PW-1:0] rec_pc,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output logic [SW-1:0] req_size,
    output logic [FW-1:0] req_flags,
    output logic [PW-1:0] req_pc,
    output logic [8*DB-1:0] req_data
);
    import rr_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_write <= 1'b0;
            req_addr  <= '0;
            req_size  <= '0;
            req_flags <= '0;
            req_pc    <= '0;
        end else if (load) begin
            req_write <= rec_write;
            req_addr  <= rec_addr;
            req_size  <= rec_size;
            req_flags <= rec_has_flags ? rec_flags : '0;
            req_pc    <= rec_has_pc ? rec_pc : '0;
        end
    end

    for (genvar b = 0; b < DB; b++) begin : g_fill
        assign req_data[8*b +: 8] = req_write ? WR_FILL_BYTE : 8'h00;
    end
endmodule

// File: rtl/rr_counter.sv
module rr_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != {CW{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/req_replayer.sv
module req_replayer #(
    parameter int TW = 32,
    parameter int AW = 32,
    parameter int SW = 8,
    parameter int FW = 8,
    parameter int PW = 32,
    parameter int DB = 8,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   tick_now,
    input  logic [TW-1:0]   time_offset,
    input  logic            rec_valid,
    output logic            rec_ready,
    input  logic            rec_eos,
    input  logic            rec_write,
    input  logic [AW-1:0]   rec_addr,
    input  logic [SW-1:0]   rec_size,
    input  logic            rec_has_flags,
    input  logic [FW-1:0]   rec_flags,
    input  logic            rec_has_pc,
    input  logic [PW-1:0]   rec_pc,
    input  logic [TW-1:0]   rec_stamp,
    output logic            req_valid,
    input  logic            req_ready,
    output logic            req_write,
    output logic [AW-1:0]   req_addr,
    output logic [SW-1:0]   req_size,
    output logic [FW-1:0]   req_flags,
    output logic [PW-1:0]   req_pc,
    output logic [8*DB-1:0] req_data,
    input  logic            retry_in,
    input  logic            rsp_valid,
    output logic            rsp_ready,
    output logic            trace_done,
    output logic            order_err,
    output logic [CW-1:0]   cnt_attempts,
    output logic [CW-1:0]   cnt_first_fail,
    output logic [CW-1:0]   cnt_retry_ok
);
    import rr_pkg::*;

    rr_state_e     state_q, state_d;
    logic [TW-1:0] target;
    logic          due, pop, load_rec, sent;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CW-1:0] cnt_arr [NUM_CNT];

    assign due      = (tick_now >= target);
    assign pop      = rec_valid && rec_ready;
    assign load_rec = pop && !rec_eos;
    assign sent     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:    if (pop) state_d = rec_eos ? ST_FINISHED : ST_ARMED;
            ST_ARMED:    if (due) state_d = req_ready ? ST_FETCH : ST_STALLED;
            ST_STALLED:  if (retry_in && req_ready) state_d = ST_FETCH;
            ST_FINISHED: state_d = ST_FINISHED;
            default:     state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        rec_ready  = 1'b0;
        req_valid  = 1'b0;
        trace_done = 1'b0;
        inc_vec    = '0;
        unique case (state_q)
            ST_FETCH:    rec_ready = 1'b1;
            ST_ARMED: begin
                req_valid  = due;
                inc_vec[0] = due;
                inc_vec[1] = due && !req_ready;
            end
            ST_STALLED: begin
                req_valid  = retry_in;
                inc_vec[2] = retry_in && req_ready;
            end
            ST_FINISHED: trace_done = 1'b1;
            default: ;
        endcase
    end

    assign rsp_ready = 1'b1;

    rr_sched #(.TW(TW)) sched_i (
        .clk(clk), .rst_n(rst_n), .load(load_rec), .sent(sent),
        .tick_now(tick_now), .time_offset(time_offset), .rec_stamp(rec_stamp),
        .target(target), .order_err(order_err)
    );

    rr_payload #(.AW(AW), .SW(SW), .FW(FW), .PW(PW), .DB(DB)) payload_i (
        .clk(clk), .rst_n(rst_n), .load(load_rec),
        .rec_write(rec_write), .rec_addr(rec_addr), .rec_size(rec_size),
        .rec_has_flags(rec_has_flags), .rec_flags(rec_flags),
        .rec_has_pc(rec_has_pc), .rec_pc(rec_pc),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_flags(req_flags), .req_pc(req_pc), .req_data(req_data)
    );

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        rr_counter #(.CW(CW)) cnt_i (
            .clk(clk), .rst_n(rst_n), .inc(inc_vec[c]), .count(cnt_arr[c])
        );
    end

    assign cnt_attempts   = cnt_arr[0];
    assign cnt_first_fail = cnt_arr[1];
    assign cnt_retry_ok   = cnt_arr[2];

    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (!req_valid || retry_in));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable({req_write, req_addr, req_size, req_flags, req_pc}));
    assert_done_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trace_done |=> (trace_done && !req_valid && !rec_ready));
    assert_wr_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_data == {DB{WR_FILL_BYTE}}));
    assert_rsp_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_ready);
    assert_fail_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_first_fail <= cnt_attempts);
endmodule

// File: tb/req_replayer_tb_top.sv
module req_replayer_tb_top;
    localparam int TW = 32, AW = 32, SW = 8, FW = 8, PW = 32, DB = 8, CW = 16;
    localparam int N = 48;
    localparam int BAD_IDX = 20;
    localparam logic [TW-1:0] OFFS = 100;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic [TW-1:0] tick = '0;
    always @(posedge clk) tick <= tick + 1;

    logic [TW-1:0] st_a [0:N];
    logic          wr_a [0:N];
    logic [AW-1:0] ad_a [0:N];
    logic [SW-1:0] sz_a [0:N];
    logic [FW-1:0] fl_a [0:N];
    logic [PW-1:0] pc_a [0:N];
    logic          hf_a [0:N];
    logic          hp_a [0:N];
    logic          bad_upto [0:N];

    int idx = 0;
    int ix;
    assign ix = (idx > N) ? N : idx;

    logic rec_valid, rec_ready, rec_eos;
    logic req_valid, req_ready, req_write, retry_in, rsp_valid, rsp_ready;
    logic trace_done, order_err;
    logic [AW-1:0] req_addr;
    logic [SW-1:0] req_size;
    logic [FW-1:0] req_flags;
    logic [PW-1:0] req_pc;
    logic [8*DB-1:0] req_data;
    logic [CW-1:0] cnt_attempts, cnt_first_fail, cnt_retry_ok;

    assign rec_valid = (idx <= N);
    assign rec_eos   = (idx == N);

    always @(posedge clk) if (rst_n && rec_valid && rec_ready) idx <= idx + 1;

    req_replayer #(.TW(TW), .AW(AW), .SW(SW), .FW(FW), .PW(PW), .DB(DB), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_now(tick), .time_offset(OFFS),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_eos(rec_eos),
        .rec_write(wr_a[ix]), .rec_addr(ad_a[ix]), .rec_size(sz_a[ix]),
        .rec_has_flags(hf_a[ix]), .rec_flags(fl_a[ix]),
        .rec_has_pc(hp_a[ix]), .rec_pc(pc_a[ix]), .rec_stamp(st_a[ix]),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_flags(req_flags),
        .req_pc(req_pc), .req_data(req_data), .retry_in(retry_in),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .trace_done(trace_done),
        .order_err(order_err), .cnt_attempts(cnt_attempts),
        .cnt_first_fail(cnt_first_fail), .cnt_retry_ok(cnt_retry_ok)
    );

    int checks = 0, fails = 0;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (tick %0d)", rq, act, exp, tick);
        end
    endtask

    function automatic logic [8*DB-1:0] exp_data(input logic w);
        return w ? {DB{8'h0A}} : '0;
    endfunction

    function automatic logic [TW-1:0] next_due(input logic [TW-1:0] t, input int k);
        logic [TW-1:0] d;
        d = (st_a[k] >= st_a[k-1]) ? st_a[k] - st_a[k-1] : '0;
        return (t + d > t + 2) ? t + d : t + 2;
    endfunction

    int k = 0, held = 0, nfail = 0, nretry = 0, cyc = 0;
    logic [TW-1:0] exp_tick;

    task automatic first_offer_checks();
        chk(k == 0 ? "R2 first issue tick" : "R3 issue tick", 64'(tick), 64'(exp_tick));
        chk("R12 address order", 64'(req_addr), 64'(ad_a[k]));
        chk("R12 command", 64'(req_write), 64'(wr_a[k]));
        chk("R12 size", 64'(req_size), 64'(sz_a[k]));
        chk("R10 flags default", 64'(req_flags), 64'(hf_a[k] ? fl_a[k] : '0));
        chk("R10 pc default", 64'(req_pc), 64'(hp_a[k] ? pc_a[k] : '0));
        chk("R7 data fill", req_data, exp_data(wr_a[k]));
        chk("R4 order flag", 64'(order_err), 64'(bad_upto[k]));
        chk("R8 rsp_ready", 64'(rsp_ready), 64'd1);
    endtask

    task automatic accepted();
        k++;
        if (k < N) exp_tick = next_due(tick, k);
    endtask

    initial begin
        void'($urandom(32'd4242));
        st_a[0] = OFFS + 30;
        for (int i = 0; i <= N; i++) begin
            if (i > 0) begin
                if (i == BAD_IDX)      st_a[i] = st_a[i-1] - 5;
                else if (i % 7 == 0)   st_a[i] = st_a[i-1];
                else                   st_a[i] = st_a[i-1] + ($urandom % 10);
            end
            wr_a[i] = 1'($urandom);
            ad_a[i] = $urandom;
            sz_a[i] = 8'($urandom);
            fl_a[i] = 8'($urandom) | 8'h01;
            pc_a[i] = $urandom | 32'h1;
            hf_a[i] = 1'($urandom);
            hp_a[i] = 1'($urandom);
            bad_upto[i] = (i >= BAD_IDX);
        end
        hf_a[0] = 1'b0; hp_a[0] = 1'b1;
        req_ready = 1'b0; retry_in = 1'b0; rsp_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 req_valid", 64'(req_valid), 64'd0);
        chk("R1 trace_done", 64'(trace_done), 64'd0);
        chk("R1 order_err", 64'(order_err), 64'd0);
        chk("R1 counters", 64'({cnt_attempts, cnt_first_fail, cnt_retry_ok}), 64'd0);
        chk("R1 rsp_ready", 64'(rsp_ready), 64'd1);
        rst_n = 1'b1;
        exp_tick = st_a[0] - OFFS;

        while (k < N && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            req_ready = ($urandom % 2) == 0;
            retry_in  = ($urandom % 4) == 0;
            rsp_valid = 1'($urandom);
            #1;
            if (held == 0) begin
                if (req_valid) begin
                    first_offer_checks();
                    if (req_ready) accepted();
                    else begin held = 1; nfail++; end
                end
            end else if (!retry_in) begin
                chk("R5 quiet while held", 64'(req_valid), 64'd0);
            end else begin
                chk("R6 valid with retry", 64'(req_valid), 64'd1);
                chk("R5 held address", 64'(req_addr), 64'(ad_a[k]));
                chk("R7 held data", req_data, exp_data(wr_a[k]));
                if (req_ready) begin held = 0; nretry++; accepted(); end
            end
        end
        if (cyc >= 20000) begin
            fails++; checks++;
            $display("FAIL R12 watchdog expired: sent=%0d expected=%0d", k, N);
        end

        repeat (4) @(negedge clk);
        #1;
        chk("R9 trace_done", 64'(trace_done), 64'd1);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            retry_in = 1'b1; req_ready = 1'b1; rsp_valid = 1'($urandom);
            #1;
            if (req_valid || rec_ready) begin
                chk("R9 quiet after end", 64'({req_valid, rec_ready}), 64'd0);
            end
        end
        chk("R9 quiet after end", 64'({req_valid, rec_ready, trace_done}), 64'd1);
        chk("R11 attempts", 64'(cnt_attempts), 64'(N));
        chk("R11 first fails", 64'(cnt_first_fail), 64'(nfail));
        chk("R11 retries ok", 64'(cnt_retry_ok), 64'(nretry));
        chk("R4 sticky order flag", 64'(order_err), 64'd1);
        chk("R8 rsp_ready", 64'(rsp_ready), 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule